// File: doc/BRIEF.md
# Secure Scan Mode Controller

This block decides whether the scan chain of a cryptographic core can be reached from the test port, and which key the core receives. After power-on it sits in an open state. In that state both scan directions pass through, the test-mode select from the boundary-scan controller reaches the core unchanged, and the core runs on a mirror key written for testing. The real secret key stays isolated.

A single decoded command from the boundary-scan controller moves the block into a locked state. In the locked state both scan paths are cut, the outgoing test-mode select is held inactive, and the core is switched to the real secret key. The lock is held in one flip-flop. No command can clear it. Only the power-on reset, which is asynchronous and active low, clears it.

Top module: `secure_scan_guard`

## Requirements
- R1: After the power-on reset is released, the block is open: scanEnIn = 1, scanEnOut = 1 and keyLoad = 0.
- R2: While locked, the block drives scanEnIn = 0, scanEnOut = 0 and keyLoad = 1.
- R3: While open, scanModeOut equals testModeIn in the same cycle.
- R4: A high secureCmd sampled on a rising clock edge locks the block from that edge onward, so the outputs change one cycle after the command is applied.
- R5: While locked, scanModeOut is 0 whatever testModeIn is.
- R6: coreKey equals mirrorKey while open and equals secretKey while locked.
- R7: scanDataOut equals chainOut while open and is a constant 0 while locked.
- R8: chainDataIn equals scanDataIn while open and is 0 while locked, so scan-in data never reaches the chain.
- R9: Once locked, the block stays locked until porRstN goes low. Toggling testModeIn, repeating secureCmd or driving scan data does not unlock it.
- R10: Asserting porRstN (low) unlocks the block at once. A secureCmd applied while the reset is held has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, asynchronous, active low |
| testModeIn | input | 1 | Test-mode select from the boundary-scan controller |
| secureCmd | input | 1 | Decoded lock command |
| scanDataIn | input | 1 | Serial scan data from the test port |
| chainOut | input | 1 | Serial data leaving the core's scan chain |
| mirrorKey | input | KEY_W | Test (mirror) key |
| secretKey | input | KEY_W | Real secret key |
| scanEnIn | output | 1 | Scan-in enable |
| scanEnOut | output | 1 | Scan-out enable |
| keyLoad | output | 1 | Secret key selected |
| scanModeOut | output | 1 | Test-mode select passed to the core |
| chainDataIn | output | 1 | Gated serial data entering the scan chain |
| scanDataOut | output | 1 | Gated serial data to the test port |
| coreKey | output | KEY_W | Key presented to the cipher core |

## Verification
The assertions are disabled while the reset is held. They assume that secureCmd and the other inputs are steady around each rising edge, and that the reset is applied at time zero. The stimulus changes every input 1 ns after a rising edge and reads the outputs on the falling edge. The reset is asserted and released at those same points, which also lets a command be applied while the reset is held.

// File: rtl/secscan_pkg.sv
package secscan_pkg;
  typedef struct packed {
    logic scanInEn;
    logic scanOutEn;
    logic keyLoad;
  } ctrlStrobes_t;
endpackage

// File: rtl/secscan_ctrl.sv
module secscan_ctrl
  import secscan_pkg::*;
(
  input  logic         clk,
  input  logic         porRstN,
  input  logic         secureCmd,
  output ctrlStrobes_t strobes
);
  logic lockQ;

  // One-way lock: only the power-on reset clears it
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) lockQ <= 1'b0;
    else if (secureCmd) lockQ <= 1'b1;
  end

  always_comb begin
    strobes.scanInEn  = ~lockQ;
    strobes.scanOutEn = ~lockQ;
    strobes.keyLoad   = lockQ;
  end
endmodule

// File: rtl/secscan_datapath.sv
module secscan_datapath
  import secscan_pkg::*;
#(
  parameter int KEY_W = 128
) (
  input  ctrlStrobes_t     strobes,
  input  logic             testModeIn,
  input  logic             scanDataIn,
  input  logic             chainOut,
  input  logic [KEY_W-1:0] mirrorKey,
  input  logic [KEY_W-1:0] secretKey,
  output logic             scanModeOut,
  output logic             chainDataIn,
  output logic             scanDataOut,
  output logic [KEY_W-1:0] coreKey
);
  always_comb begin
    scanModeOut = testModeIn & ~strobes.keyLoad;
    chainDataIn = scanDataIn & strobes.scanInEn;
    scanDataOut = chainOut & strobes.scanOutEn;
    coreKey     = strobes.keyLoad ? secretKey : mirrorKey;
  end
endmodule

// File: rtl/secure_scan_guard.sv
module secure_scan_guard
  import secscan_pkg::*;
#(
  parameter int KEY_W = 128
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic             testModeIn,
  input  logic             secureCmd,
  input  logic             scanDataIn,
  input  logic             chainOut,
  input  logic [KEY_W-1:0] mirrorKey,
  input  logic [KEY_W-1:0] secretKey,
  output logic             scanEnIn,
  output logic             scanEnOut,
  output logic             keyLoad,
  output logic             scanModeOut,
  output logic             chainDataIn,
  output logic             scanDataOut,
  output logic [KEY_W-1:0] coreKey
);
  ctrlStrobes_t strobes;

  secscan_ctrl u_ctrl (
    .clk       (clk),
    .porRstN   (porRstN),
    .secureCmd (secureCmd),
    .strobes   (strobes)
  );

  secscan_datapath #(.KEY_W(KEY_W)) u_dp (
    .strobes     (strobes),
    .testModeIn  (testModeIn),
    .scanDataIn  (scanDataIn),
    .chainOut    (chainOut),
    .mirrorKey   (mirrorKey),
    .secretKey   (secretKey),
    .scanModeOut (scanModeOut),
    .chainDataIn (chainDataIn),
    .scanDataOut (scanDataOut),
    .coreKey     (coreKey)
  );

  assign scanEnIn  = strobes.scanInEn;
  assign scanEnOut = strobes.scanOutEn;
  assign keyLoad   = strobes.keyLoad;
endmodule

// File: rtl/secure_scan_guard_chk.sv
module secure_scan_guard_chk #(
  parameter int KEY_W = 128
) (
  input logic             clk,
  input logic             porRstN,
  input logic             testModeIn,
  input logic             secureCmd,
  input logic             scanDataIn,
  input logic             chainOut,
  input logic [KEY_W-1:0] mirrorKey,
  input logic [KEY_W-1:0] secretKey,
  input logic             scanEnIn,
  input logic             scanEnOut,
  input logic             keyLoad,
  input logic             scanModeOut,
  input logic             chainDataIn,
  input logic             scanDataOut,
  input logic [KEY_W-1:0] coreKey
);
  // R4
  cmd_locks_chk: assert property (@(posedge clk) disable iff (!porRstN)
    secureCmd |=> keyLoad);
  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!porRstN)
    keyLoad |=> keyLoad);
  // R2
  locked_gates_chk: assert property (@(posedge clk) disable iff (!porRstN)
    keyLoad |-> (!scanEnIn && !scanEnOut));
  // R1
  open_enables_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !keyLoad |-> (scanEnIn && scanEnOut));
  // R3
  open_mode_pass_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !keyLoad |-> (scanModeOut == testModeIn));
  // R5
  locked_mode_off_chk: assert property (@(posedge clk) disable iff (!porRstN)
    keyLoad |-> !scanModeOut);
  // R6
  key_secret_chk: assert property (@(posedge clk) disable iff (!porRstN)
    keyLoad |-> (coreKey == secretKey));
  // R6
  key_mirror_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !keyLoad |-> (coreKey == mirrorKey));
  // R7
  scan_out_block_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !scanEnOut |-> !scanDataOut);
  // R8
  scan_in_block_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !scanEnIn |-> !chainDataIn);
endmodule

bind secure_scan_guard secure_scan_guard_chk #(.KEY_W(KEY_W)) u_chk (.*);

// File: tb/secure_scan_guard_tb.sv
`timescale 1ns/1ps
module secure_scan_guard_tb;
  localparam int KEY_W = 128;

  typedef struct packed {
    logic             scanEnIn;
    logic             scanEnOut;
    logic             keyLoad;
    logic             scanModeOut;
    logic             chainDataIn;
    logic             scanDataOut;
    logic [KEY_W-1:0] coreKey;
  } outItem_t;

  logic clk = 1'b0;
  logic porRstN = 1'b0;
  logic testModeIn = 1'b0, secureCmd = 1'b0, scanDataIn = 1'b0, chainOut = 1'b0;
  logic [KEY_W-1:0] mirrorKey = {4{32'h1357_9BDF}};
  logic [KEY_W-1:0] secretKey = {4{32'hC0DE_5EC1}};
  logic scanEnIn, scanEnOut, keyLoad, scanModeOut, chainDataIn, scanDataOut;
  logic [KEY_W-1:0] coreKey;

  outItem_t expQ[$];
  string    tagQ[$];
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic lockModel = 1'b0;

  always #2.5 clk = ~clk;

  secure_scan_guard #(.KEY_W(KEY_W)) u_dut (.*);

  // Driver: applies one cycle of stimulus and queues the expected outputs
  task automatic drive(input logic rstN, input logic tm, input logic cmd,
                       input logic sdi, input logic cho, input string tag);
    outItem_t e;
    @(posedge clk);
    #1;
    porRstN = rstN; testModeIn = tm; secureCmd = cmd;
    scanDataIn = sdi; chainOut = cho;
    if (!rstN) lockModel = 1'b0;
    e.scanEnIn    = !lockModel;
    e.scanEnOut   = !lockModel;
    e.keyLoad     = lockModel;
    e.scanModeOut = lockModel ? 1'b0 : tm;
    e.chainDataIn = lockModel ? 1'b0 : sdi;
    e.scanDataOut = lockModel ? 1'b0 : cho;
    e.coreKey     = lockModel ? secretKey : mirrorKey;
    expQ.push_back(e);
    tagQ.push_back(tag);
    if (rstN && cmd) lockModel = 1'b1;
  endtask

  // Monitor: compares at the falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      outItem_t e;
      outItem_t a;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      a = '{scanEnIn, scanEnOut, keyLoad, scanModeOut, chainDataIn, scanDataOut, coreKey};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R10 reset held");
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1 open after reset");
    // R3 R7 R8 R6: open pass-through under varied patterns
    for (int i = 0; i < 8; i++)
      drive(1'b1, i[0], 1'b0, i[1], i[2], "R3 R7 R8 R6 open pass");
    // R10: command during reset ignored
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R10 cmd under reset");
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R10 still open");
    // R4: lock applied, effect one cycle later
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R4 cmd cycle still open");
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R4 R2 locked next cycle");
    // R5 R7 R8 R9: locked under test commands and data
    for (int i = 0; i < 8; i++)
      drive(1'b1, i[0], i[1], i[2], ~i[0], "R5 R7 R8 R9 locked");
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R9 repeat cmd");
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R6 secret key");
    // R10: only reset reopens
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R10 reset clears lock");
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R1 reopened");
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R6 mirror key again");
    @(posedge clk);
    @(negedge clk);
    #1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule